// File: doc/BRIEF.md
# Wake-up Line Selector and Edge Detector

This block watches a set of candidate wake signals on behalf of a power-mode controller. It has eight wake lines. Each line picks one of three candidate inputs, looks for an edge of a chosen direction on it, and records a sticky flag. Any flag whose line is enabled raises the combined wake request. The power-mode controller uses that request to leave stop, standby or shutdown states.

Every candidate input first passes through a two-stage synchroniser. Software sets the lines up through a small register port, which holds an enable mask, a polarity mask and a packed source-select word. The same port reads the flags and clears them by writing ones. A configuration write blanks detection for one cycle. Re-pointing a line or flipping its polarity therefore never produces a false wake.

Top module: `wake_sel_det`

## Requirements
- R1: After reset the enable, polarity, select and status registers read 0 and `wake_req_o` is 0.
- R2: Register map (address: content). 0 is the enable mask, bits 7:0. 1 is the polarity mask, bits 7:0. 2 is the select word, bits 15:0, with line n's code in bits 2n+1:2n. 3 is the status flags, bits 7:0, read-only. 4 is the clear register, which reads 0. Bits above a register's width read 0, and a write to address 3 has no effect.
- R3: For line n, select code k (0, 1 or 2) picks candidate input `src_i[8k+n]`. Edges on any other input never set that line's flag.
- R4: A polarity bit of 1 detects rising edges and 0 detects falling edges. A qualifying edge driven on `src_i` just after one clock edge shows in the status flag after the third following rising clock edge, and not after the second.
- R5: A line whose enable bit is 0 never sets its flag. Clearing an enable bit keeps that line's polarity and select settings.
- R6: Select code 3 is reserved, and a line set to it never sets its flag.
- R7: Flags are sticky until a 1 is written to the matching bit of address 4. When a detection and a clear hit the same flag in the same cycle, the flag stays set.
- R8: `wake_req_o` is 1 exactly when some flag is set on an enabled line. Disabling a line masks its flag from the request but does not clear the flag.
- R9: A write to address 0, 1 or 2 blocks detection in the cycle after it. Moving a line to a source at a different level does not set its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 24 | Candidate wake signals, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| wake_req_o | output | 1 | Combined wake request |

## Verification
A wrong source mapping or polarity shows up as a status bit that stays 0 after an edge that should set it, or one that sets on the wrong input. Either can be seen on the fourth clock after the input toggles. A history register that lost its value, or a missing blanking cycle, shows as a flag set right after a select write with no input activity. A faulty clear priority or request mask shows in the status read and on `wake_req_o` in the cycle after the write.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int unsigned NUM_LINES    = 8;
  localparam int unsigned SRC_PER_LINE = 3;
  localparam int unsigned SYNC_STAGES  = 2;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned ADDR_W       = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE   = 3'd0,
    REG_POLARITY = 3'd1,
    REG_SELECT   = 3'd2,
    REG_STATUS   = 3'd3,
    REG_CLEAR    = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int unsigned WIDTH  = 24,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wk_regs.sv
module wk_regs
  import wk_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic [NUM_LINES-1:0]       flags_i,
  output logic [NUM_LINES-1:0]       en_o,
  output logic [NUM_LINES-1:0]       pol_o,
  output logic [NUM_LINES*SEL_W-1:0] sel_o,
  output logic                       hold_o,
  output logic [NUM_LINES-1:0]       clr_o
);
  localparam int unsigned SELW_TOT = NUM_LINES * SEL_W;

  logic [NUM_LINES-1:0] en_q, pol_q;
  logic [SELW_TOT-1:0]  sel_q;
  logic                 hold_q;
  logic                 cfg_wr;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:SELW_TOT];

  assign cfg_wr = we_i && (addr_i == REG_ENABLE || addr_i == REG_POLARITY ||
                           addr_i == REG_SELECT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '0;
      sel_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= cfg_wr;
      if (we_i && addr_i == REG_ENABLE)   en_q  <= wdata_i[NUM_LINES-1:0];
      if (we_i && addr_i == REG_POLARITY) pol_q <= wdata_i[NUM_LINES-1:0];
      if (we_i && addr_i == REG_SELECT)   sel_q <= wdata_i[SELW_TOT-1:0];
    end
  end

  assign clr_o = (we_i && addr_i == REG_CLEAR) ? wdata_i[NUM_LINES-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_ENABLE:   rdata_o[NUM_LINES-1:0] = en_q;
      REG_POLARITY: rdata_o[NUM_LINES-1:0] = pol_q;
      REG_SELECT:   rdata_o[SELW_TOT-1:0]  = sel_q;
      REG_STATUS:   rdata_o[NUM_LINES-1:0] = flags_i;
      default:      rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign sel_o  = sel_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/wk_line.sv
module wk_line #(
  parameter int unsigned SRC_PER_LINE = 3,
  parameter int unsigned SEL_W        = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SRC_PER_LINE-1:0] cand_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic                    pol_i,
  input  logic                    en_i,
  input  logic                    hold_i,
  input  logic                    clr_i,
  output logic                    flag_o
);
  logic cur, valid, prev_q, flag_q;
  logic rise, fall, edge_hit, det;

  always_comb begin
    cur   = 1'b0;
    valid = 1'b0;
    for (int k = 0; k < SRC_PER_LINE; k++) begin
      if (sel_i == SEL_W'(k)) begin
        cur   = cand_i[k];
        valid = 1'b1;
      end
    end
  end

  // history follows the selected input every cycle; hold_i masks the cycle after a re-point
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cur;
  end

  assign rise     = cur & ~prev_q;
  assign fall     = ~cur & prev_q;
  assign edge_hit = pol_i ? rise : fall;
  assign det      = en_i & valid & ~hold_i & edge_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= (flag_q & ~clr_i) | det;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/wake_sel_det.sv
module wake_sel_det
  import wk_pkg::*;
#(
  parameter int unsigned NUM_LINES    = wk_pkg::NUM_LINES,
  parameter int unsigned SRC_PER_LINE = wk_pkg::SRC_PER_LINE,
  parameter int unsigned SYNC_STAGES  = wk_pkg::SYNC_STAGES,
  parameter int unsigned DATA_W       = wk_pkg::DATA_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_LINES*SRC_PER_LINE-1:0] src_i,
  input  logic                              reg_we_i,
  input  logic [ADDR_W-1:0]                 reg_addr_i,
  input  logic [DATA_W-1:0]                 reg_wdata_i,
  output logic [DATA_W-1:0]                 reg_rdata_o,
  output logic                              wake_req_o
);
  localparam int unsigned NUM_SRC = NUM_LINES * SRC_PER_LINE;
  localparam int unsigned SEL_W   = $clog2(SRC_PER_LINE + 1);

  logic [NUM_SRC-1:0]         src_s;
  logic [NUM_LINES-1:0]       en_w, pol_w, clr_w, flags_w;
  logic [NUM_LINES*SEL_W-1:0] sel_w;
  logic                       hold_w;

  wk_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (src_s)
  );

  wk_regs #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .flags_i(flags_w),
    .en_o   (en_w),
    .pol_o  (pol_w),
    .sel_o  (sel_w),
    .hold_o (hold_w),
    .clr_o  (clr_w)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [SRC_PER_LINE-1:0] cand;
    for (genvar k = 0; k < SRC_PER_LINE; k++) begin : g_cand
      assign cand[k] = src_s[k*NUM_LINES + n];
    end

    wk_line #(.SRC_PER_LINE(SRC_PER_LINE), .SEL_W(SEL_W)) u_line (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cand_i(cand),
      .sel_i (sel_w[n*SEL_W +: SEL_W]),
      .pol_i (pol_w[n]),
      .en_i  (en_w[n]),
      .hold_i(hold_w),
      .clr_i (clr_w[n]),
      .flag_o(flags_w[n])
    );
  end

  assign wake_req_o = |(flags_w & en_w);
endmodule

// File: rtl/wake_sel_det_chk.sv
module wake_sel_det_chk
  import wk_pkg::*;
#(
  parameter int unsigned NUM_LINES    = 8,
  parameter int unsigned SRC_PER_LINE = 3,
  parameter int unsigned SEL_W        = 2,
  parameter int unsigned DATA_W       = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       reg_we_i,
  input logic [ADDR_W-1:0]          reg_addr_i,
  input logic [DATA_W-1:0]          reg_wdata_i,
  input logic [DATA_W-1:0]          reg_rdata_o,
  input logic                       wake_req_o,
  input logic [NUM_LINES-1:0]       en_i,
  input logic [NUM_LINES*SEL_W-1:0] sel_i,
  input logic [NUM_LINES-1:0]       flags_i,
  input logic                       hold_i
);
  p_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == REG_ENABLE) |-> (reg_rdata_o[DATA_W-1:NUM_LINES] == '0));

  p_clear_reads_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == REG_CLEAR) |-> (reg_rdata_o == '0));

  p_idle_no_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !wake_req_o);

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_chk
    p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flags_i[n]) |-> $past(reg_we_i && reg_addr_i == REG_CLEAR && reg_wdata_i[n]));

    p_disabled_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_i[n]) |-> $past(en_i[n]));

    p_reserved_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_i[n]) |-> ($past(sel_i[n*SEL_W +: SEL_W]) < SEL_W'(SRC_PER_LINE)));

    p_hold_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_i[n]) |-> !$past(hold_i));
  end
endmodule

bind wake_sel_det wake_sel_det_chk #(
  .NUM_LINES   (NUM_LINES),
  .SRC_PER_LINE(SRC_PER_LINE),
  .SEL_W       (SEL_W),
  .DATA_W      (DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .wake_req_o (wake_req_o),
  .en_i       (en_w),
  .sel_i      (sel_w),
  .flags_i    (flags_w),
  .hold_i     (hold_w)
);

// File: tb/wake_sel_det_tb.sv
module wake_sel_det_tb;
  localparam int NL = 8;
  localparam int NS = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          wake;

  int checks = 0;
  int errors = 0;

  logic [NL-1:0]   en_m = '0, pol_m = '0, flags_m = '0;
  logic [2*NL-1:0] sel_m = '0;

  always #10 clk = ~clk;

  wake_sel_det u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .src_i      (src),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .wake_req_o (wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    case (a)
      3'd0: en_m = d[NL-1:0];
      3'd1: pol_m = d[NL-1:0];
      3'd2: sel_m = d[2*NL-1:0];
      3'd4: flags_m = flags_m & ~d[NL-1:0];
      default: ;
    endcase
  endtask

  // lines whose settings turn a change of src[b] to level v into a wake
  function automatic logic [NL-1:0] hits(input int b, input logic v);
    logic [NL-1:0] h = '0;
    for (int n = 0; n < NL; n++) begin
      int code = int'(sel_m[2*n +: 2]);
      if (en_m[n] && code != 3 && code * NL + n == b && pol_m[n] == v) h[n] = 1'b1;
    end
    return h;
  endfunction

  task automatic toggle(input int b);
    @(negedge clk);
    src[b] = ~src[b];
    flags_m = flags_m | hits(b, src[b]);
    repeat (4) @(posedge clk);
  endtask

  task automatic check_state(input string req);
    logic [31:0] d;
    rd(3'd3, d);
    chk(req, d, {24'h0, flags_m});
    chk(req, {31'h0, wake}, {31'h0, |(flags_m & en_m)});
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd48213));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 reset reg", d, 32'h0);
    end
    chk("R1 reset req", {31'h0, wake}, 32'h0);

    // R2 register map
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); chk("R2 enable width", d, 32'h0000_00FF);
    wr(3'd1, 32'h1234_56A5); rd(3'd1, d); chk("R2 polarity", d, 32'h0000_00A5);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, d); chk("R2 select width", d, 32'h0000_FFFF);
    wr(3'd3, 32'h0000_00FF); rd(3'd3, d); chk("R2 status read-only", d, 32'h0);
    rd(3'd4, d); chk("R2 clear reads zero", d, 32'h0);
    wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd2, 32'h0);

    // R3 mapping: line 2 code 1 -> src[10], rising
    wr(3'd2, 32'h0000_0010);
    wr(3'd1, 32'h0000_0004);
    wr(3'd0, 32'h0000_0004);
    toggle(2);  check_state("R3 unselected input");
    toggle(18); check_state("R3 unselected input");
    // R4 latency on the selected rising edge
    @(negedge clk); src[10] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 3'd3; #1;
    chk("R4 not before third edge", {31'h0, rdata[2]}, 32'h0);
    @(posedge clk);
    @(negedge clk); #1;
    chk("R4 after third edge", {31'h0, rdata[2]}, 32'h1);
    flags_m[2] = 1'b1;
    check_state("R8 request with flag");

    // R7 detection beats same-cycle clear
    toggle(10);
    @(negedge clk); src[10] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); we = 1'b1; addr = 3'd4; wdata = 32'h4;
    @(negedge clk); we = 1'b0;
    repeat (2) @(posedge clk);
    check_state("R7 detect wins over clear");
    wr(3'd4, 32'h4);
    check_state("R7 clear by write-one");
    toggle(10);

    // R4 falling: line 5 code 2 -> src[21]
    wr(3'd2, 32'h0000_0810);
    wr(3'd0, 32'h0000_0024);
    toggle(21); check_state("R4 rising ignored on falling line");
    toggle(21); check_state("R4 falling detected");
    chk("R4 falling flag", {31'h0, flags_m[5]}, 32'h1);

    // R8 disable masks request, flag kept
    wr(3'd0, 32'h0000_0004);
    check_state("R8 masked by disable");
    chk("R8 req low", {31'h0, wake}, 32'h0);
    wr(3'd0, 32'h0000_0024);
    check_state("R8 unmasked");
    wr(3'd4, 32'hFF);
    check_state("R8 cleared");

    // R6 reserved code on line 1
    wr(3'd2, 32'h0000_000C);
    wr(3'd1, 32'h0000_0002);
    wr(3'd0, 32'h0000_0002);
    for (int i = 0; i < 2; i++) begin
      toggle(1); toggle(9); toggle(17);
    end
    check_state("R6 reserved code quiet");
    chk("R6 flag zero", {24'h0, flags_m}, 32'h0);

    // R5 disabled line 3, settings retained
    wr(3'd2, 32'h0000_0040);
    wr(3'd1, 32'h0000_0008);
    wr(3'd0, 32'h0000_0000);
    toggle(11); toggle(11);
    check_state("R5 disabled quiet");
    rd(3'd2, d); chk("R5 select kept", d, 32'h0000_0040);
    rd(3'd1, d); chk("R5 polarity kept", d, 32'h0000_0008);
    wr(3'd0, 32'h0000_0008);
    toggle(11);
    check_state("R5 enabled detects");
    wr(3'd4, 32'hFF);

    // R9 re-point line 0 from low src[0] to high src[8], rising
    if (src[0]) toggle(0);
    if (!src[8]) toggle(8);
    wr(3'd2, 32'h0); wr(3'd1, 32'h1); wr(3'd0, 32'h1);
    wr(3'd2, 32'h1);
    repeat (3) @(posedge clk);
    check_state("R9 no false edge on re-point");
    chk("R9 flag zero", {31'h0, flags_m[0]}, 32'h0);

    // random phase (R3 R4 R5 R6 R7 R8)
    wr(3'd1, $urandom); wr(3'd2, $urandom); wr(3'd0, 32'hFF);
    for (int it = 0; it < 250; it++) begin
      int r = $urandom_range(0, 9);
      if (r < 2) begin
        wr(3'($urandom_range(0, 2)), $urandom);
        repeat (2) @(posedge clk);
      end else if (r == 2) begin
        wr(3'd4, $urandom);
      end else begin
        toggle($urandom_range(0, NS - 1));
      end
      check_state("R3 R4 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule